// File: doc/BRIEF.md
# Single-Wire Control Bus Transmit Bit Timer

This block produces the transmit waveform for a consumer-electronics-control style single-wire bus. Time on the bus is counted in ticks of a slow timebase enable, `tick`, which pulses for one cycle of the fast system clock. A frame opens with a start request. The block then emits one start bit and serializes data bits, taking each over a valid/ready handshake. A last flag on the bit marks the end of the frame.

Every bit has two phases. The line is first pulled low, and is then released high for the rest of the bit period. Four trim inputs shorten the start-bit low phase, the start-bit period, the data-bit low phase and the data-bit period. Each trim counts in whole ticks below a fixed base count. The output `lineRelease` is meant to feed an open-drain pad: 0 pulls the wire low and 1 lets it float high. Bit order within a byte is set by the source that feeds the handshake, and the block sends bits in the order it accepts them.

Top module: `cec_tx_timing`

## Requirements
- R1: While reset is active, and after it until a start request, `lineRelease` is 1, and `busy`, `bitReady` and `underrun` are 0.
- R2: The start bit holds the line low for 121 minus `startRiseTrim` ticks, counted from the first cycle after the start request is taken.
- R3: The start bit period, from one falling edge to the next bit's falling edge or to the end of busy, is 147 minus `startPeriodTrim` ticks.
- R4: A data bit holds the line low for 20 ticks when `bitData` is 1 and 49 ticks when it is 0. This low time is reduced by `dataRiseTrim` when that code is 0 to 3.
- R5: `dataRiseTrim` codes 4 to 7 are reserved and act as a trim of zero.
- R6: The data bit period is 79 minus `dataPeriodTrim` ticks, where `dataPeriodTrim` is 4 bits wide.
- R7: All trims are sampled in the cycle a bit begins and hold for that bit. A change during a bit affects only later bits.
- R8: `bitReady` is high only in the final cycle of a bit that is not last, and a bit is taken when `bitValid` and `bitReady` are both high. After the period of a bit taken with `bitLast` = 1, `busy` falls and the line stays released.
- R9: A start request while `busy` is high is ignored: the bit timing in progress is unchanged and no new frame follows.
- R10: If `bitValid` is low when a data bit is needed, the frame ends with the line released, `busy` falls, and `underrun` is high for exactly one cycle.
- R11: The tick counters advance only on cycles where `tick` is high, so with a tick every N clocks every phase lasts N times its tick count in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable, one pulse per tick |
| startReq | input | 1 | Start a frame (ignored while busy) |
| startRiseTrim | input | 3 | Ticks removed from the start-bit low phase |
| startPeriodTrim | input | 3 | Ticks removed from the start-bit period |
| dataRiseTrim | input | 3 | Ticks removed from the data-bit low phase (codes 4 to 7 act as 0) |
| dataPeriodTrim | input | 4 | Ticks removed from the data-bit period |
| bitValid | input | 1 | Source offers a data bit |
| bitData | input | 1 | Value of the offered bit |
| bitLast | input | 1 | Offered bit is the last of the frame |
| bitReady | output | 1 | Block takes the offered bit this cycle |
| lineRelease | output | 1 | 1 releases the bus, 0 pulls it low |
| busy | output | 1 | A frame is in progress |
| underrun | output | 1 | One-cycle pulse when a needed bit was missing |

## Verification
The hardest case to reach is a trim that changes part-way through a bit. From the ports alone, such a change looks the same as one made at a bit boundary unless it lands inside a low phase and the following bit is measured too. The bench therefore switches the data trims a few cycles into the first data bit of a two-bit frame, using a cycle-indexed override on the trim inputs. It then expects the old timing on that bit and the new timing on the next. A start request is injected the same way in the middle of a frame. Another run uses a tick every third clock to show that all timing follows `tick` and not the clock.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
  // Strobes from the control FSM to the timing datapath
  typedef struct packed {
    logic loadStart;  // begin the start bit, sample start trims
    logic loadData;   // begin a data bit, sample data trims
    logic run;        // a frame is active, counter runs on tick
  } txStrobe_t;
endpackage

// File: rtl/cec_tx_datapath.sv
module cec_tx_datapath
  import cec_tx_pkg::*;
#(
  parameter int START_LOW_BASE = 121,
  parameter int START_PER_BASE = 147,
  parameter int ONE_LOW_BASE   = 20,
  parameter int ZERO_LOW_BASE  = 49,
  parameter int DATA_PER_BASE  = 79,
  parameter int SR_W = 3,
  parameter int SP_W = 3,
  parameter int DR_W = 3,
  parameter int DP_W = 4,
  parameter int DR_VALID_MAX = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  txStrobe_t       strb,
  input  logic [SR_W-1:0] startRiseTrim,
  input  logic [SP_W-1:0] startPeriodTrim,
  input  logic [DR_W-1:0] dataRiseTrim,
  input  logic [DP_W-1:0] dataPeriodTrim,
  input  logic            bitData,
  output logic            lineLow,
  output logic            bitEnd
);
  localparam int CNT_W = $clog2(START_PER_BASE + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lowLen;
  logic [CNT_W-1:0] perLen;
  logic [CNT_W-1:0] dataRiseEff;
  logic [CNT_W-1:0] dataLowBase;

  // Reserved rise-trim codes fall back to zero trim
  always_comb begin
    if (int'(dataRiseTrim) > DR_VALID_MAX) dataRiseEff = '0;
    else dataRiseEff = CNT_W'(dataRiseTrim);
    dataLowBase = bitData ? CNT_W'(ONE_LOW_BASE) : CNT_W'(ZERO_LOW_BASE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      lowLen <= '0;
      perLen <= '0;
    end else if (strb.loadStart) begin
      cnt    <= '0;
      lowLen <= CNT_W'(START_LOW_BASE) - CNT_W'(startRiseTrim);
      perLen <= CNT_W'(START_PER_BASE) - CNT_W'(startPeriodTrim);
    end else if (strb.loadData) begin
      cnt    <= '0;
      lowLen <= dataLowBase - dataRiseEff;
      perLen <= CNT_W'(DATA_PER_BASE) - CNT_W'(dataPeriodTrim);
    end else if (strb.run && tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign bitEnd  = strb.run && tick && (cnt == perLen - CNT_W'(1));
  assign lineLow = strb.run && (cnt < lowLen);

  // R11: no tick, no progress
  p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !tick) |=> $stable(cnt));
  // R2/R4: the low phase always ends before the bit period does
  p_low_before_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && $past(strb.run)) |-> (lowLen < perLen));
endmodule

// File: rtl/cec_tx_ctrl.sv
module cec_tx_ctrl
  import cec_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      bitValid,
  input  logic      bitLast,
  input  logic      bitEnd,
  output logic      bitReady,
  output logic      busy,
  output logic      underrun,
  output txStrobe_t strb
);
  logic curLast;
  logic needBit;
  logic takeBit;
  logic starve;
  logic finish;

  always_comb begin
    needBit = bitEnd && !curLast;
    takeBit = needBit && bitValid;
    starve  = needBit && !bitValid;
    finish  = bitEnd && curLast;
    strb.loadStart = !busy && startReq;
    strb.loadData  = takeBit;
    strb.run       = busy;
  end

  assign bitReady = needBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      curLast  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= starve;
      if (strb.loadStart) begin
        busy    <= 1'b1;
        curLast <= 1'b0;
      end else if (finish || starve) begin
        busy <= 1'b0;
      end else if (takeBit) begin
        curLast <= bitLast;
      end
    end
  end

  // R8: the handshake opens only inside a frame
  p_ready_in_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    bitReady |-> busy);
  // R10: an underrun pulse coincides with the frame having ended
  p_underrun_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> !busy);
  // R10: the pulse lasts one cycle
  p_underrun_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun);
  // R9: a start request mid-bit cannot disturb the frame
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !bitEnd) |=> busy);
endmodule

// File: rtl/cec_tx_timing.sv
module cec_tx_timing
  import cec_tx_pkg::*;
#(
  parameter int START_LOW_BASE = 121,
  parameter int START_PER_BASE = 147,
  parameter int ONE_LOW_BASE   = 20,
  parameter int ZERO_LOW_BASE  = 49,
  parameter int DATA_PER_BASE  = 79,
  parameter int SR_W = 3,
  parameter int SP_W = 3,
  parameter int DR_W = 3,
  parameter int DP_W = 4,
  parameter int DR_VALID_MAX = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            startReq,
  input  logic [SR_W-1:0] startRiseTrim,
  input  logic [SP_W-1:0] startPeriodTrim,
  input  logic [DR_W-1:0] dataRiseTrim,
  input  logic [DP_W-1:0] dataPeriodTrim,
  input  logic            bitValid,
  input  logic            bitData,
  input  logic            bitLast,
  output logic            bitReady,
  output logic            lineRelease,
  output logic            busy,
  output logic            underrun
);
  txStrobe_t strb;
  logic      lineLow;
  logic      bitEnd;

  cec_tx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .bitValid (bitValid),
    .bitLast  (bitLast),
    .bitEnd   (bitEnd),
    .bitReady (bitReady),
    .busy     (busy),
    .underrun (underrun),
    .strb     (strb)
  );

  cec_tx_datapath #(
    .START_LOW_BASE (START_LOW_BASE),
    .START_PER_BASE (START_PER_BASE),
    .ONE_LOW_BASE   (ONE_LOW_BASE),
    .ZERO_LOW_BASE  (ZERO_LOW_BASE),
    .DATA_PER_BASE  (DATA_PER_BASE),
    .SR_W           (SR_W),
    .SP_W           (SP_W),
    .DR_W           (DR_W),
    .DP_W           (DP_W),
    .DR_VALID_MAX   (DR_VALID_MAX)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .tick            (tick),
    .strb            (strb),
    .startRiseTrim   (startRiseTrim),
    .startPeriodTrim (startPeriodTrim),
    .dataRiseTrim    (dataRiseTrim),
    .dataPeriodTrim  (dataPeriodTrim),
    .bitData         (bitData),
    .lineLow         (lineLow),
    .bitEnd          (bitEnd)
  );

  assign lineRelease = !lineLow;

  // R8/R1: outside a frame the bus is never pulled low
  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> lineRelease);
endmodule

// File: tb/cec_tx_timing_tb.sv
`timescale 1ns/1ps
module cec_tx_timing_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick;
  logic startReq;
  logic [2:0] startRiseTrim, startPeriodTrim, dataRiseTrim;
  logic [3:0] dataPeriodTrim;
  logic bitValid, bitData, bitLast;
  logic bitReady, lineRelease, busy, underrun;

  always #2.5 clk = ~clk;

  // stimulus controls
  int   cyc = 0;
  int   tickDiv = 1;
  int   tickCnt = 0;
  logic startDrv = 1'b0;
  int   pokeCyc = -1;
  int   trimCyc = 32'h7fffffff;
  logic [2:0] sRise = 0, sPer = 0, dRise = 0, dRiseAlt = 0;
  logic [3:0] dPer = 0, dPerAlt = 0;
  logic fbits [8];
  int   fLen = 0;
  int   fIdx = 0;
  logic feedEn = 1'b0;
  logic feedClr = 1'b0;
  int   mLow [8];
  int   mPer [8];
  int   nTests = 0;
  int   nFail = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tickCnt <= (tickCnt + 1 >= tickDiv) ? 0 : tickCnt + 1;
    if (feedClr) fIdx <= 0;
    else if (bitReady && bitValid) fIdx <= fIdx + 1;
  end

  assign tick            = (tickDiv == 1) ? 1'b1 : (tickCnt == 0);
  assign startReq        = startDrv || (cyc == pokeCyc);
  assign startRiseTrim   = sRise;
  assign startPeriodTrim = sPer;
  assign dataRiseTrim    = (cyc >= trimCyc) ? dRiseAlt : dRise;
  assign dataPeriodTrim  = (cyc >= trimCyc) ? dPerAlt : dPer;
  assign bitValid        = feedEn && (fIdx < fLen);
  assign bitData         = (fIdx < 8) ? fbits[fIdx] : 1'b0;
  assign bitLast         = (fIdx == fLen - 1);

  cec_tx_timing u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .startReq(startReq),
    .startRiseTrim(startRiseTrim), .startPeriodTrim(startPeriodTrim),
    .dataRiseTrim(dataRiseTrim), .dataPeriodTrim(dataPeriodTrim),
    .bitValid(bitValid), .bitData(bitData), .bitLast(bitLast),
    .bitReady(bitReady), .lineRelease(lineRelease), .busy(busy),
    .underrun(underrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic measure(output int lowC, output int perC);
    lowC = 0;
    while (lineRelease == 1'b0 && lowC < 4000) begin lowC++; @(negedge clk); end
    perC = lowC;
    while (lineRelease == 1'b1 && busy && perC < 4000) begin perC++; @(negedge clk); end
  endtask

  // Launch a frame; nMeas bits (start included) are measured
  task automatic runFrame(input int nBits, input bit valid, input int nMeas,
                          input int pokeOff, input int trimOff);
    @(negedge clk);
    feedClr = 1'b1; feedEn = valid; fLen = nBits;
    @(negedge clk);
    feedClr = 1'b0; startDrv = 1'b1;
    pokeCyc = (pokeOff > 0) ? cyc + pokeOff : -1;
    trimCyc = (trimOff > 0) ? cyc + trimOff : 32'h7fffffff;
    @(negedge clk);
    startDrv = 1'b0;
    for (int k = 0; k < nMeas; k++) measure(mLow[k], mPer[k]);
  endtask

  // sRise, sPer, dRise, dPer, bit, expStartLow, expStartPer, expDataLow, expDataPer
  localparam int NV = 6;
  localparam int VEC [NV][9] = '{
    '{0, 0, 0, 0,  1, 121, 147, 20, 79},
    '{7, 7, 3, 15, 0, 114, 140, 46, 64},
    '{3, 5, 2, 8,  1, 118, 142, 18, 71},
    '{1, 2, 5, 1,  1, 120, 145, 20, 78},   // reserved rise code 5
    '{0, 0, 7, 4,  0, 121, 147, 49, 75},   // reserved rise code 7
    '{5, 1, 1, 0,  0, 116, 146, 48, 79}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 8; i++) fbits[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(lineRelease == 1'b1, "R1 line in reset", lineRelease, 1);
    check(busy == 1'b0 && bitReady == 1'b0 && underrun == 1'b0,
          "R1 busy/ready/underrun in reset", busy + bitReady + underrun, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(lineRelease == 1'b1 && busy == 1'b0, "R1 idle after reset",
          lineRelease, 1);

    // Table: one start bit plus one last data bit per vector (R2 R3 R4 R5 R6)
    for (int v = 0; v < NV; v++) begin
      sRise = 3'(VEC[v][0]); sPer = 3'(VEC[v][1]);
      dRise = 3'(VEC[v][2]); dPer = 4'(VEC[v][3]);
      fbits[0] = 1'(VEC[v][4]);
      runFrame(1, 1'b1, 2, 0, 0);
      check(mLow[0] == VEC[v][5], "R2 start low", mLow[0], VEC[v][5]);
      check(mPer[0] == VEC[v][6], "R3 start period", mPer[0], VEC[v][6]);
      check(mLow[1] == VEC[v][7], "R4/R5 data low", mLow[1], VEC[v][7]);
      check(mPer[1] == VEC[v][8], "R6 data period", mPer[1], VEC[v][8]);
      check(busy == 1'b0 && lineRelease == 1'b1, "R8 frame end", busy, 0);
    end
    sRise = 0; sPer = 0; dRise = 0; dPer = 0;

    // R8: three-bit frame 1,0,1 taken in order over the handshake
    fbits[0] = 1'b1; fbits[1] = 1'b0; fbits[2] = 1'b1;
    runFrame(3, 1'b1, 4, 0, 0);
    check(mLow[1] == 20, "R8 bit0 low", mLow[1], 20);
    check(mLow[2] == 49, "R8 bit1 low", mLow[2], 49);
    check(mLow[3] == 20, "R8 bit2 low", mLow[3], 20);
    check(mPer[2] == 79, "R8 bit1 period", mPer[2], 79);
    check(fIdx == 3, "R8 bits taken", fIdx, 3);
    check(busy == 1'b0 && lineRelease == 1'b1, "R8 released after last", busy, 0);

    // R7: trims change 5 cycles into the first data bit low phase
    fbits[0] = 1'b1; fbits[1] = 1'b1;
    dRiseAlt = 3'd2; dPerAlt = 4'd10;
    runFrame(2, 1'b1, 3, 0, 147 + 6);
    check(mLow[1] == 20, "R7 bit held old rise trim", mLow[1], 20);
    check(mPer[1] == 79, "R7 bit held old period trim", mPer[1], 79);
    check(mLow[2] == 18, "R7 next bit new rise trim", mLow[2], 18);
    check(mPer[2] == 69, "R7 next bit new period trim", mPer[2], 69);
    dRiseAlt = 0; dPerAlt = 0;

    // R9: start request in the middle of the start bit is ignored
    fbits[0] = 1'b0;
    runFrame(1, 1'b1, 2, 60, 0);
    check(mLow[0] == 121, "R9 start low unchanged", mLow[0], 121);
    check(mPer[0] == 147, "R9 start period unchanged", mPer[0], 147);
    check(mLow[1] == 49 && mPer[1] == 79, "R9 data bit unchanged", mPer[1], 79);
    begin
      int seenBusy = 0;
      for (int k = 0; k < 20; k++) begin
        if (busy || !lineRelease) seenBusy++;
        @(negedge clk);
      end
      check(seenBusy == 0, "R9 no second frame", seenBusy, 0);
    end

    // R10: no bit offered when one is needed
    runFrame(1, 1'b0, 1, 0, 0);
    check(mPer[0] == 147, "R10 start bit completes", mPer[0], 147);
    check(underrun == 1'b1 && busy == 1'b0 && lineRelease == 1'b1,
          "R10 underrun pulse", underrun, 1);
    @(negedge clk);
    check(underrun == 1'b0, "R10 pulse one cycle", underrun, 0);

    // R11: tick every third clock scales data bit timing
    tickDiv = 3;
    fbits[0] = 1'b1; fbits[1] = 1'b0;
    runFrame(2, 1'b1, 3, 0, 0);
    check(mLow[1] == 60, "R11 data one low", mLow[1], 60);
    check(mPer[1] == 237, "R11 data period", mPer[1], 237);
    check(mLow[2] == 147, "R11 data zero low", mLow[2], 147);
    check(mPer[2] == 237, "R11 last period", mPer[2], 237);
    tickDiv = 1;

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule